// File: doc/BRIEF.md
# Measurement Conversion Sequencer

This block decides when the shunt and bus channels of a power monitor are sampled. Software programs a 16-bit configuration word that selects an operating mode (continuous, single-shot on demand, converter off or power-down) and, separately for each channel, either one conversion at a reduced resolution or a power-of-two number of samples to be averaged. The sequencer asks an external sample source for one raw sample at a time. It reduces or averages the samples it receives and holds one signed result per channel.

A conversion-ready flag tells software that a whole pass has finished. A pass is every enabled channel with all of its samples. The flag has separate set and clear rules. A pass completion sets it. A configuration write in an active mode clears it, and so does a read of the bus result. Any configuration write cancels the pass in progress, and the sequencer starts again under the new settings. Setting bit 15 of a written word restores the power-on state.

Configuration layout: bits [2:0] mode, bits [6:3] shunt field, bits [10:7] bus field, bits [14:11] stored only, bit 15 soft reset (never stored).

Top module: `meas_conv_seq`

## Requirements
- R1: After reset, cfg_rdata reads 0x399F, both results read 0, conv_ready is 0, and the first sample request is for the shunt channel (smp_chan = 0) with smp_field = 4'b0011.
- R2: Mode bit 0 enables the shunt channel and mode bit 1 enables the bus channel (smp_chan 0 = shunt, 1 = bus). When both are enabled, every shunt sample of a pass is requested before the first bus sample. smp_req stays high with a steady smp_chan until smp_valid is given.
- R3: Modes 001, 010 and 011 run exactly one pass and then issue no further requests. Writing such a mode code again starts a new pass even if the same code is already stored.
- R4: Modes 101, 110 and 111 start a new pass as soon as the previous one finishes.
- R5: Modes 000 and 100 issue no requests. A write of either mode leaves both results and conv_ready unchanged.
- R6: A channel field with bit 3 = 1 averages 2^k samples, where k = field[2:0]. The result is the floor of the signed sum divided by 2^k.
- R7: A channel field with bit 3 = 0 takes one sample at 9 + field[1:0] bits. The result is that sample with its (3 − field[1:0]) low bits cleared, which rounds toward minus infinity. Field bit 2 has no effect.
- R8: conv_ready rises only after a pass completes, and both results of that pass are already visible when it does.
- R9: conv_ready clears on a configuration write whose mode is not 000 or 100, and on a bus_rd pulse. If a pass completes in the same cycle as bus_rd, the flag is set.
- R10: A write with bit 15 set restores cfg_rdata to 0x399F, clears both results and conv_ready, and restarts continuous sequencing.
- R11: A configuration write during a pass drops smp_req at once. Samples already taken in that pass are discarded, and the new pass uses the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Stored configuration word |
| bus_rd | input | 1 | Pulse marking a read of the bus result |
| smp_req | output | 1 | Request for one raw sample, held until answered |
| smp_chan | output | 1 | Channel of the request (0 shunt, 1 bus) |
| smp_field | output | 4 | Resolution/averaging field of the requested channel |
| smp_valid | input | 1 | Sample source delivers smp_data |
| smp_data | input | 16 | Signed raw sample |
| shunt_res | output | 16 | Latest signed shunt result |
| bus_res | output | 16 | Latest signed bus result |
| conv_ready | output | 1 | Conversion-ready flag |

## Verification
A wrong sample count or a wrong channel order shows in the first pass. The bench sees it as a wrong number of shunt samples delivered before the first bus request, or as a wrong averaged value when the flag rises, a few tens of cycles after the write. A corrupted sequencer state after a single-shot pass shows as requests that continue during the idle window the bench watches. A ready flag that is set too early or cleared by the wrong event is visible at the port on the cycle after the triggering write, read or pass completion.

// File: rtl/meas_conv_pkg.sv
package meas_conv_pkg;

  localparam int SMP_W        = 16;
  localparam int AVG_LOG2_MAX = 7;
  localparam int ACC_W        = SMP_W + AVG_LOG2_MAX;
  localparam logic [SMP_W-1:0] CFG_POR = 16'h399F;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_FINISH} seq_state_t;
  typedef enum logic {CH_SHUNT = 1'b0, CH_BUS = 1'b1} chan_t;

  typedef struct packed {
    logic       soft_rst;
    logic [3:0] spare;
    logic [3:0] bus_fld;
    logic [3:0] shunt_fld;
    logic [2:0] mode;
  } cfg_t;

  // mode helpers: bit0 shunt, bit1 bus, bit2 continuous
  function automatic logic mode_stopped(input logic [2:0] m);
    return (m[1:0] == 2'b00);
  endfunction

  // number of averaged samples as a log2
  function automatic logic [2:0] fld_log2(input logic [3:0] f);
    return f[3] ? f[2:0] : 3'd0;
  endfunction

  // low bits discarded in single-conversion mode
  function automatic logic [1:0] fld_drop(input logic [3:0] f);
    return f[3] ? 2'd0 : (2'd3 - f[1:0]);
  endfunction

  function automatic logic [SMP_W-1:0] trim_lsbs(input logic [SMP_W-1:0] s,
                                                  input logic [1:0] drop);
    logic [SMP_W-1:0] keep;
    keep = {SMP_W{1'b1}} << drop;
    return s & keep;
  endfunction

  function automatic logic [SMP_W-1:0] avg_scale(input logic signed [ACC_W-1:0] acc,
                                                  input logic [2:0] sh);
    logic signed [ACC_W-1:0] t;
    t = acc >>> sh;
    return t[SMP_W-1:0];
  endfunction

endpackage

// File: rtl/mcs_cfg_reg.sv
module mcs_cfg_reg
  import meas_conv_pkg::*;
#(
  parameter logic [SMP_W-1:0] RESET_CFG = CFG_POR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SMP_W-1:0] cfg_wdata,
  output cfg_t             cfg_q,
  output logic             restart_q,
  output logic             soft_rst,
  output logic             rdy_clr
);

  cfg_t wr_word;
  assign wr_word  = cfg_t'(cfg_wdata);
  assign soft_rst = cfg_wr & wr_word.soft_rst;
  assign rdy_clr  = cfg_wr & (wr_word.soft_rst | !mode_stopped(wr_word.mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= cfg_t'(RESET_CFG);
      restart_q <= 1'b1;
    end else begin
      restart_q <= cfg_wr;
      if (cfg_wr) begin
        if (wr_word.soft_rst) cfg_q <= cfg_t'(RESET_CFG);
        else                  cfg_q <= wr_word;
      end
    end
  end

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
  import meas_conv_pkg::*;
#(
  parameter int CNT_W = AVG_LOG2_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       restart,
  input  logic [2:0] mode,
  input  logic [3:0] shunt_fld,
  input  logic [3:0] bus_fld,
  input  logic       smp_valid,
  output logic       smp_req,
  output chan_t      chan,
  output logic [3:0] cur_fld,
  output logic       take,
  output logic       first,
  output logic       chan_done,
  output logic       pass_done
);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W:0]   span;
  chan_t            first_chan;

  assign cur_fld    = (chan == CH_SHUNT) ? shunt_fld : bus_fld;
  assign span       = (CNT_W+1)'(1) << fld_log2(cur_fld);
  assign last_idx   = CNT_W'(span - 1'b1);
  assign first_chan = mode[0] ? CH_SHUNT : CH_BUS;

  assign smp_req    = (state == ST_WAIT);
  assign take       = (state == ST_WAIT) & smp_valid & !abort;
  assign first      = (cnt == '0);
  assign chan_done  = take & (cnt == last_idx);
  assign pass_done  = (state == ST_FINISH) & !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      chan  <= CH_SHUNT;
      cnt   <= '0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (restart && !mode_stopped(mode)) begin
          state <= ST_LAUNCH;
          chan  <= first_chan;
          cnt   <= '0;
        end
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: if (take) begin
          if (chan_done) begin
            if (chan == CH_SHUNT && mode[1]) begin
              chan  <= CH_BUS;
              cnt   <= '0;
              state <= ST_LAUNCH;
            end else begin
              state <= ST_FINISH;
            end
          end else begin
            cnt   <= cnt + 1'b1;
            state <= ST_LAUNCH;
          end
        end
        ST_FINISH: if (mode[2]) begin
          state <= ST_LAUNCH;
          chan  <= first_chan;
          cnt   <= '0;
        end else begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcs_accum.sv
module mcs_accum
  import meas_conv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [3:0]       fld,
  input  logic [SMP_W-1:0] sample,
  output logic [SMP_W-1:0] result
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;
  logic signed [ACC_W-1:0] smp_ext;

  assign smp_ext  = ACC_W'(signed'(sample));
  assign acc_next = first ? smp_ext : (acc_q + smp_ext);
  assign result   = fld[3] ? avg_scale(acc_next, fld_log2(fld))
                           : trim_lsbs(sample, fld_drop(fld));

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_next;
  end

endmodule

// File: rtl/mcs_result.sv
module mcs_result
  import meas_conv_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             chan_done,
  input  chan_t            chan,
  input  logic [SMP_W-1:0] result,
  input  logic             pass_done,
  input  logic             rdy_clr,
  input  logic             bus_rd,
  output logic [SMP_W-1:0] res_q [NCH],
  output logic             ready
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n || soft_rst)                      res_q[g] <= '0;
      else if (chan_done && (int'(chan) == g))     res_q[g] <= result;
    end
  end

  // set has priority over the clear by bus read
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst)      ready <= 1'b0;
    else if (pass_done)          ready <= 1'b1;
    else if (rdy_clr || bus_rd)  ready <= 1'b0;
  end

endmodule

// File: rtl/meas_conv_seq.sv
module meas_conv_seq
  import meas_conv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        bus_rd,
  output logic        smp_req,
  output logic        smp_chan,
  output logic [3:0]  smp_field,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  output logic [15:0] shunt_res,
  output logic [15:0] bus_res,
  output logic        conv_ready
);

  cfg_t             cfg_q;
  logic             restart_q, soft_rst, rdy_clr;
  chan_t            chan;
  logic             take, first, chan_done, pass_done;
  logic [SMP_W-1:0] result;
  logic [SMP_W-1:0] res_q [2];

  mcs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .restart_q(restart_q), .soft_rst(soft_rst), .rdy_clr(rdy_clr)
  );

  mcs_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .abort(cfg_wr), .restart(restart_q),
    .mode(cfg_q.mode), .shunt_fld(cfg_q.shunt_fld), .bus_fld(cfg_q.bus_fld),
    .smp_valid(smp_valid), .smp_req(smp_req), .chan(chan), .cur_fld(smp_field),
    .take(take), .first(first), .chan_done(chan_done), .pass_done(pass_done)
  );

  mcs_accum u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first),
    .fld(smp_field), .sample(smp_data), .result(result)
  );

  mcs_result #(.NCH(2)) u_res (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .chan_done(chan_done),
    .chan(chan), .result(result), .pass_done(pass_done), .rdy_clr(rdy_clr),
    .bus_rd(bus_rd), .res_q(res_q), .ready(conv_ready)
  );

  assign cfg_rdata = cfg_q;
  assign smp_chan  = chan;
  assign shunt_res = res_q[0];
  assign bus_res   = res_q[1];

endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
  parameter logic [15:0] POR_WORD = 16'h399F
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic        bus_rd,
  input logic        smp_req,
  input logic        smp_chan,
  input logic        smp_valid,
  input logic        conv_ready,
  input logic        pass_done,
  input logic        chan_done
);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req && !smp_valid && !cfg_wr |=> smp_req && $stable(smp_chan));

  assert_single_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done && !cfg_rdata[2] && !cfg_wr |=> !smp_req);

  assert_stop_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1:0] == 2'b00) |-> !smp_req);

  assert_ready_after_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_ready) |-> $past(pass_done));

  assert_busrd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !pass_done |=> !conv_ready);

  assert_cfgwr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_wdata[1:0] != 2'b00) |=> !conv_ready);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_wdata[15] |=> (cfg_rdata == POR_WORD) && !conv_ready);

  assert_abort_drops_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !smp_req && !chan_done);

endmodule

bind meas_conv_seq mcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .bus_rd(bus_rd), .smp_req(smp_req), .smp_chan(smp_chan),
  .smp_valid(smp_valid), .conv_ready(conv_ready), .pass_done(pass_done),
  .chan_done(chan_done)
);

// File: tb/meas_conv_seq_test.sv
`timescale 1ns/1ps
module meas_conv_seq_test;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bus_rd = 1'b0;
  logic        smp_req, smp_chan;
  logic [3:0]  smp_field;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [15:0] shunt_res, bus_res;
  logic        conv_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // sample source model state
  int sh_base = 0, sh_step = 0, bu_base = 0, bu_step = 0;
  int sh_given = 0, bu_given = 0, sh_before_bus = -1;
  int lat_cnt = 0;

  always #2.5 clk = ~clk;

  meas_conv_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_rd(bus_rd), .smp_req(smp_req), .smp_chan(smp_chan),
    .smp_field(smp_field), .smp_valid(smp_valid), .smp_data(smp_data),
    .shunt_res(shunt_res), .bus_res(bus_res), .conv_ready(conv_ready)
  );

  always @(negedge clk) begin
    if (!rst_n || !smp_req) begin
      smp_valid = 1'b0;
      lat_cnt   = 0;
    end else if (!smp_valid) begin
      lat_cnt++;
      if (lat_cnt == LAT) begin
        smp_valid = 1'b1;
        if (smp_chan == 1'b0) begin
          smp_data = 16'(sh_base + sh_step * sh_given);
          sh_given++;
        end else begin
          if (sh_before_bus < 0) sh_before_bus = sh_given;
          smp_data = 16'(bu_base + bu_step * bu_given);
          bu_given++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    sh_given = 0; bu_given = 0; sh_before_bus = -1;
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!conv_ready && n < 5000) begin @(negedge clk); n++; end
    chk(req, 32'(conv_ready), 32'd1);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] avg_exp(input int base, input int step, input int n);
    int sum = 0;
    int q;
    for (int i = 0; i < n; i++) sum += base + step * i;
    q = sum / n;
    if (sum < 0 && (sum % n) != 0) q -= 1;
    return 16'(q);
  endfunction

  function automatic logic [15:0] trim_exp(input int v, input int bits);
    int d = 1 << (12 - bits);
    int q = v / d;
    if (v < 0 && (v % d) != 0) q -= 1;
    return 16'(q * d);
  endfunction

  task automatic t_reset();
    chk("R1 cfg", 32'(cfg_rdata), 32'h399F);
    chk("R1 ready", 32'(conv_ready), 32'd0);
    chk("R1 shunt", 32'(shunt_res), 32'd0);
    chk("R1 bus", 32'(bus_res), 32'd0);
    while (!smp_req) @(negedge clk);
    chk("R1 first chan", 32'(smp_chan), 32'd0);
    chk("R1 field", 32'(smp_field), 32'h3);
  endtask

  task automatic t_continuous();
    wait_ready("R4 first pass");
    chk("R1 shunt value", 32'(shunt_res), 32'h0123);
    chk("R1 bus value", 32'(bus_res), 32'h0456);
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R9 bus read clears", 32'(conv_ready), 32'd0);
    wait_ready("R4 next pass");
  endtask

  task automatic t_avg_trig();
    sh_base = -50; sh_step = -13; bu_base = 1000; bu_step = 3;
    wr_cfg(16'h055B);
    clr_counts();
    wait_ready("R8 triggered pass");
    chk("R6 shunt avg8", 32'(shunt_res), 32'(avg_exp(-50, -13, 8)));
    chk("R6 bus avg4", 32'(bus_res), 32'(avg_exp(1000, 3, 4)));
    chk("R2 shunt first", 32'(sh_before_bus), 32'd8);
    clr_counts();
    idle_cycles(150);
    chk("R3 no more samples", 32'(sh_given + bu_given), 32'd0);
    wr_cfg(16'h055B);
    chk("R9 write clears", 32'(conv_ready), 32'd0);
    clr_counts();
    wait_ready("R3 rewrite same code");
    chk("R3 second pass count", 32'(sh_given * 16 + bu_given), 32'(8 * 16 + 4));
  endtask

  task automatic t_reduced();
    sh_base = 16'h0FFF; sh_step = 0;
    wr_cfg(16'h0521);
    clr_counts();
    wait_ready("R7 9-bit pass");
    chk("R7 9-bit bit2 ignored", 32'(shunt_res), 32'(trim_exp(32'h0FFF, 9)));
    chk("R2 bus untouched", 32'(bus_res), 32'(avg_exp(1000, 3, 4)));
    chk("R2 no bus sample", 32'(bu_given), 32'd0);
    sh_base = -5;
    wr_cfg(16'h0511);
    clr_counts();
    wait_ready("R7 11-bit pass");
    chk("R7 11-bit negative", 32'(shunt_res), 32'(trim_exp(-5, 11)));
  endtask

  task automatic t_bus_only();
    bu_base = 16'h2ABC; bu_step = 0;
    wr_cfg(16'h019A);
    clr_counts();
    wait_ready("R2 bus triggered");
    chk("R2 bus value", 32'(bus_res), 32'h2ABC);
    chk("R2 shunt kept", 32'(shunt_res), 32'hFFFA);
    chk("R2 no shunt sample", 32'(sh_given), 32'd0);
  endtask

  task automatic t_stop();
    wr_cfg(16'h019C);
    clr_counts();
    chk("R5 off keeps ready", 32'(conv_ready), 32'd1);
    idle_cycles(100);
    chk("R5 off no samples", 32'(sh_given + bu_given), 32'd0);
    chk("R5 off results", 32'({shunt_res, bus_res}), 32'hFFFA2ABC);
    wr_cfg(16'h0198);
    clr_counts();
    chk("R5 pd keeps ready", 32'(conv_ready), 32'd1);
    idle_cycles(100);
    chk("R5 pd no samples", 32'(sh_given + bu_given), 32'd0);
    chk("R5 pd results", 32'({shunt_res, bus_res}), 32'hFFFA2ABC);
  endtask

  task automatic t_abort();
    int n = 0;
    sh_base = 100; sh_step = 1;
    wr_cfg(16'h01DF);
    clr_counts();
    while (sh_given < 3 && n < 2000) begin @(negedge clk); n++; end
    sh_base = 777; sh_step = 0; bu_base = 555; bu_step = 0;
    wr_cfg(16'h019B);
    chk("R11 req dropped", 32'(smp_req), 32'd0);
    chk("R11 ready low", 32'(conv_ready), 32'd0);
    clr_counts();
    wait_ready("R11 restarted pass");
    chk("R11 new shunt", 32'(shunt_res), 32'd777);
    chk("R11 new bus", 32'(bus_res), 32'd555);
    chk("R11 one shunt sample", 32'(sh_given), 32'd1);
  endtask

  task automatic t_soft_reset();
    wr_cfg(16'h8000);
    chk("R10 cfg", 32'(cfg_rdata), 32'h399F);
    chk("R10 ready", 32'(conv_ready), 32'd0);
    chk("R10 results", 32'({shunt_res, bus_res}), 32'd0);
    clr_counts();
    wait_ready("R10 continuous restart");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    sh_base = 16'h0123; bu_base = 16'h0456;
    idle_cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_continuous();
    t_avg_trig();
    t_reduced();
    t_bus_only();
    t_stop();
    t_abort();
    t_soft_reset();
    finish_run();
  end

endmodule